// File: doc/BRIEF.md
# Three-Wire Serial Register Loader

This block takes words from a host over three wires: a serial clock, a data line and a frame-select line. It loads them into the configuration registers of a frequency-synthesis and audio subsystem. The three wires are first brought into the system clock domain. Data bits are then shifted in, most significant first, on each detected rising edge of the serial clock. The level of the frame-select line splits the registers into two spaces. Each change of that level closes the frame that was collected while the line sat at its old level. The closed frame is then either committed to one register or dropped.

While the select line is low, a frame carries 16 bits, and its two leading bits pick one of four registers:
- the transmit divider,
- the receive divider,
- the reference divider with its region-select pair,
- the control word of power-save, mute and test flags.

While the line is high, a frame whose leading bit is 1 writes a separate register. That register holds a 4-bit battery-threshold code and a 6-bit oscillator-capacitor selection. The host may pad this frame to 12 or 16 bits. Every decoded field is driven out as a plain output for the blocks that consume it.

Top module: `tri_wire_loader`

## Requirements
- R1: After reset the outputs hold their defaults: transmit divider 9966, receive divider 7215, reference divider 2048 with region 00, every control flag 0, capacitor selection 0, battery code 0000.
- R2: Bits enter most significant first, one per synchronized rising edge of `ser_clk`. A frame collected while `ser_en` is low is applied after `ser_en` rises.
- R3: A low-level frame of exactly 16 bits is routed by bits 15:14: 11 writes bits 13:0 to the transmit divider, 01 writes them to the receive divider, 10 writes the reference register, 00 writes the control register.
- R4: In a reference frame, bits 13:12 go to `ref_region` and bits 11:0 go to `ref_div`.
- R5: In a control frame the fields are taken from these bits: 12 `tx_save`, 11 `comp_mute`, 10 `comp_save`, 9 `exp_mute`, 8 `exp_save`, 7 `lock_sel`, 6 `batt_save`, 5 `rx_save`, 1:0 `test_mode`. Bits 13 and 4:2 are ignored.
- R6: A frame collected while `ser_en` is high is applied after `ser_en` falls. When it is 12 bits with bit 11 set, or 16 bits with bit 15 set, its low ten bits are stored: bits 9:6 to `batt_code` and bits 5:0 to `cap_sel`. The padding bits between the leading bit and bit 9 are ignored.
- R7: A frame with any other bit count, or a high-level frame whose leading bit is 0, changes no output.
- R8: `batt_level` is one-hot. Code 0000 sets bit 0, 0001 sets bit 1, 0010 sets bit 2, 0100 sets bit 3 and 1000 sets bit 4. Any other code sets bit 0.
- R9: Outputs change only in the cycles where a valid frame is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock from the host |
| ser_data | input | 1 | Serial data, MSB first |
| ser_en | input | 1 | Frame-select level; its changes close frames |
| tx_div | output | 14 | Transmit channel divider |
| rx_div | output | 14 | Receive channel divider |
| ref_div | output | 12 | Reference divider |
| ref_region | output | 2 | Reference region select |
| tx_save | output | 1 | Transmit synthesizer power-save |
| comp_mute | output | 1 | Compressor mute |
| comp_save | output | 1 | Compressor power-save |
| exp_mute | output | 1 | Expander mute |
| exp_save | output | 1 | Expander power-save |
| lock_sel | output | 1 | Lock-indicator / carrier-detect output select |
| batt_save | output | 1 | Battery detector power-save |
| rx_save | output | 1 | Receiver power-save |
| test_mode | output | 2 | Test mode bits |
| cap_sel | output | 6 | Oscillator capacitor selection |
| batt_code | output | 4 | Raw battery-threshold code |
| batt_level | output | 5 | One-hot battery-threshold selection |

## Verification
Each of the four low-level routing codes is driven with asymmetric data words. A swapped register target or a reversed bit order would give a visibly wrong divider. High-level frames are sent at both legal lengths, with padding of ones and of zeros, which shows whether the capacitor and battery fields are taken from the tail of the frame. Frames one bit short, one bit long and of odd lengths, plus high-level frames with a clear leading bit, must leave every output untouched. A reference model compares all outputs on every clock outside the short commit window.

// File: rtl/p3w_pkg.sv
package p3w_pkg;
   localparam int FRAME_LONG  = 16;
   localparam int FRAME_SHORT = 12;
   localparam int DIV_W       = 14;
   localparam int REF_W       = 12;
   localparam int CAP_W       = 6;
   localparam int CODE_W      = 4;
   localparam int LEVELS      = CODE_W + 1;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'b00,
      SEL_RX   = 2'b01,
      SEL_REF  = 2'b10,
      SEL_TX   = 2'b11
   } sel_e;

   typedef struct packed {
      logic       tx_save;
      logic       comp_mute;
      logic       comp_save;
      logic       exp_mute;
      logic       exp_save;
      logic       lock_sel;
      logic       batt_save;
      logic       rx_save;
      logic [1:0] test_mode;
   } ctrl_t;

   localparam logic [DIV_W-1:0] TX_RST  = DIV_W'(9966);
   localparam logic [DIV_W-1:0] RX_RST  = DIV_W'(7215);
   localparam logic [REF_W-1:0] REF_RST = REF_W'(2048);
endpackage

// File: rtl/p3w_sync.sv
module p3w_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("p3w_sync needs at least two stages");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d_i;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/p3w_frame_collect.sv
module p3w_frame_collect #(
   parameter int FRAME_LONG = 16,
   parameter int CNT_W      = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sclk_i,
   input  logic                  sdat_i,
   input  logic                  sen_i,
   output logic [FRAME_LONG-1:0] word_o,
   output logic [CNT_W-1:0]      nbits_o,
   output logic                  done_o,
   output logic                  lvl_o
);
   localparam int CNT_SAT = FRAME_LONG + 1;

   generate
      if ((1 << CNT_W) <= CNT_SAT) begin : g_bad_cnt
         $error("bit counter too narrow for frame length");
      end
   endgenerate

   logic                  sclk_q, sen_q;
   logic [FRAME_LONG-1:0] sreg;
   logic [CNT_W-1:0]      cnt;
   logic                  sclk_rise, level_change;

   assign sclk_rise    = sclk_i & ~sclk_q;
   assign level_change = sen_i ^ sen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q  <= 1'b0;
         sen_q   <= 1'b0;
         sreg    <= '0;
         cnt     <= '0;
         word_o  <= '0;
         nbits_o <= '0;
         done_o  <= 1'b0;
         lvl_o   <= 1'b0;
      end else begin
         sclk_q <= sclk_i;
         sen_q  <= sen_i;
         done_o <= 1'b0;
         if (level_change) begin
            done_o  <= 1'b1;
            lvl_o   <= sen_q;
            word_o  <= sreg;
            nbits_o <= cnt;
            sreg    <= '0;
            cnt     <= '0;
         end else if (sclk_rise) begin
            sreg <= {sreg[FRAME_LONG-2:0], sdat_i};
            if (cnt != CNT_W'(CNT_SAT)) cnt <= cnt + 1'b1;
         end
      end
   end

   assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(CNT_SAT));

   assert_frame_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (cnt <= CNT_W'(1)));
endmodule

// File: rtl/p3w_level_dec.sv
module p3w_level_dec #(
   parameter int CODE_W = 4
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [CODE_W:0]   level_o
);
   logic [CODE_W-1:0] hit;

   generate
      for (genvar k = 0; k < CODE_W; k++) begin : g_lvl
         assign hit[k]       = (code_i == CODE_W'(1 << k));
         assign level_o[k+1] = hit[k];
      end
   endgenerate

   assign level_o[0] = ~|hit;

   always_comb begin
      assert_level_onehot_R8: assert ($onehot(level_o));
   end
endmodule

// File: rtl/p3w_regbank.sv
module p3w_regbank
   import p3w_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [FRAME_LONG-1:0] word_i,
   input  logic [CNT_W-1:0]      nbits_i,
   input  logic                  done_i,
   input  logic                  lvl_i,
   output logic [DIV_W-1:0]      tx_div_o,
   output logic [DIV_W-1:0]      rx_div_o,
   output logic [REF_W-1:0]      ref_div_o,
   output logic [1:0]            ref_region_o,
   output ctrl_t                 ctrl_o,
   output logic [CAP_W-1:0]      cap_o,
   output logic [CODE_W-1:0]     code_o
);
   localparam int TAIL_W = CODE_W + CAP_W;

   generate
      if (FRAME_LONG != DIV_W + 2) begin : g_bad_div
         $error("divider width must leave two routing bits");
      end
      if (REF_W + 4 != FRAME_LONG) begin : g_bad_ref
         $error("reference frame layout mismatch");
      end
      if (TAIL_W >= FRAME_SHORT) begin : g_bad_tail
         $error("short frame must hold lead bit and tail");
      end
   endgenerate

   logic  lo_ok, hi_short, hi_long, hi_ok;
   sel_e  sel;
   ctrl_t ctrl_nx;
   logic  unused_ctrl_bits;

   assign sel      = sel_e'(word_i[FRAME_LONG-1 -: 2]);
   assign lo_ok    = done_i & ~lvl_i & (nbits_i == CNT_W'(FRAME_LONG));
   assign hi_short = (nbits_i == CNT_W'(FRAME_SHORT)) & word_i[FRAME_SHORT-1];
   assign hi_long  = (nbits_i == CNT_W'(FRAME_LONG))  & word_i[FRAME_LONG-1];
   assign hi_ok    = done_i & lvl_i & (hi_short | hi_long);

   assign ctrl_nx = '{tx_save:   word_i[12], comp_mute: word_i[11],
                      comp_save: word_i[10], exp_mute:  word_i[9],
                      exp_save:  word_i[8],  lock_sel:  word_i[7],
                      batt_save: word_i[6],  rx_save:   word_i[5],
                      test_mode: word_i[1:0]};
   assign unused_ctrl_bits = ^{word_i[13], word_i[4:2]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_div_o     <= TX_RST;
         rx_div_o     <= RX_RST;
         ref_div_o    <= REF_RST;
         ref_region_o <= 2'b00;
         ctrl_o       <= '0;
         cap_o        <= '0;
         code_o       <= '0;
      end else begin
         if (lo_ok) begin
            unique case (sel)
               SEL_TX:  tx_div_o <= word_i[DIV_W-1:0];
               SEL_RX:  rx_div_o <= word_i[DIV_W-1:0];
               SEL_REF: begin
                  ref_region_o <= word_i[REF_W+1:REF_W];
                  ref_div_o    <= word_i[REF_W-1:0];
               end
               default: ctrl_o <= ctrl_nx;
            endcase
         end
         if (hi_ok) begin
            code_o <= word_i[TAIL_W-1:CAP_W];
            cap_o  <= word_i[CAP_W-1:0];
         end
      end
   end

   assert_tx_low_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_div_o != $past(tx_div_o)) |-> $past(done_i && !lvl_i));

   assert_ref_low_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_div_o != $past(ref_div_o)) |-> $past(done_i && !lvl_i));

   assert_cap_high_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_o != $past(cap_o)) |-> $past(done_i && lvl_i));

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(done_i) |-> ($stable(rx_div_o) && $stable(ctrl_o) && $stable(code_o)
                          && $stable(ref_region_o)));
endmodule

// File: rtl/tri_wire_loader.sv
module tri_wire_loader
   import p3w_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ser_clk,
   input  logic        ser_data,
   input  logic        ser_en,
   output logic [13:0] tx_div,
   output logic [13:0] rx_div,
   output logic [11:0] ref_div,
   output logic [1:0]  ref_region,
   output logic        tx_save,
   output logic        comp_mute,
   output logic        comp_save,
   output logic        exp_mute,
   output logic        exp_save,
   output logic        lock_sel,
   output logic        batt_save,
   output logic        rx_save,
   output logic [1:0]  test_mode,
   output logic [5:0]  cap_sel,
   output logic [3:0]  batt_code,
   output logic [4:0]  batt_level
);
   localparam int CNT_W = $clog2(FRAME_LONG + 2) + 1;

   logic [2:0]            pins_s;
   logic [FRAME_LONG-1:0] word;
   logic [CNT_W-1:0]      nbits;
   logic                  done, lvl;
   ctrl_t                 ctrl;

   p3w_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d_i({ser_en, ser_data, ser_clk}), .q_o(pins_s));

   p3w_frame_collect #(.FRAME_LONG(FRAME_LONG), .CNT_W(CNT_W)) u_collect (
      .clk(clk), .rst_n(rst_n),
      .sclk_i(pins_s[0]), .sdat_i(pins_s[1]), .sen_i(pins_s[2]),
      .word_o(word), .nbits_o(nbits), .done_o(done), .lvl_o(lvl));

   p3w_regbank #(.CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .word_i(word), .nbits_i(nbits), .done_i(done), .lvl_i(lvl),
      .tx_div_o(tx_div), .rx_div_o(rx_div), .ref_div_o(ref_div),
      .ref_region_o(ref_region), .ctrl_o(ctrl), .cap_o(cap_sel), .code_o(batt_code));

   p3w_level_dec #(.CODE_W(CODE_W)) u_level (
      .code_i(batt_code), .level_o(batt_level));

   assign tx_save   = ctrl.tx_save;
   assign comp_mute = ctrl.comp_mute;
   assign comp_save = ctrl.comp_save;
   assign exp_mute  = ctrl.exp_mute;
   assign exp_save  = ctrl.exp_save;
   assign lock_sel  = ctrl.lock_sel;
   assign batt_save = ctrl.batt_save;
   assign rx_save   = ctrl.rx_save;
   assign test_mode = ctrl.test_mode;
endmodule

// File: tb/tb_tri_wire_loader.sv
`timescale 1ns/1ps
module tb_tri_wire_loader;
   logic clk = 1'b0, rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_data = 1'b0, ser_en = 1'b1;
   logic [13:0] tx_div, rx_div;
   logic [11:0] ref_div;
   logic [1:0]  ref_region, test_mode;
   logic tx_save, comp_mute, comp_save, exp_mute, exp_save, lock_sel, batt_save, rx_save;
   logic [5:0] cap_sel;
   logic [3:0] batt_code;
   logic [4:0] batt_level;

   always #4 clk = ~clk;

   tri_wire_loader dut (.*);

   int tests = 0, fails = 0, cycle = 0, quiet_until = 0;
   bit done_all = 0;

   // reference model state
   int m_tx = 9966, m_rx = 7215, m_ref = 2048, m_reg = 0, m_ctrl = 0, m_cap = 0, m_code = 0;

   task automatic chk(string tag, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycle);
      end
   endtask

   function automatic int lvl_of(int code);
      case (code)
         1: return 2;
         2: return 4;
         4: return 8;
         8: return 16;
         default: return 1;
      endcase
   endfunction

   function automatic int ctrl_act();
      return {tx_save, comp_mute, comp_save, exp_mute, exp_save, lock_sel,
              batt_save, rx_save, 3'b000, test_mode};
   endfunction

   task automatic cmp_all(string ctx);
      chk({ctx, " R3 tx"}, tx_div, m_tx);
      chk({ctx, " R3 rx"}, rx_div, m_rx);
      chk({ctx, " R4 ref"}, ref_div, m_ref);
      chk({ctx, " R4 region"}, ref_region, m_reg);
      chk({ctx, " R5 ctrl"}, ctrl_act(), m_ctrl);
      chk({ctx, " R6 cap"}, cap_sel, m_cap);
      chk({ctx, " R6 code"}, batt_code, m_code);
      chk({ctx, " R8 level"}, batt_level, lvl_of(m_code));
   endtask

   // per-clock comparison against the model (R9: nothing moves between commits)
   always @(negedge clk) begin
      cycle++;
      if (rst_n && !done_all && cycle > quiet_until) cmp_all("R9 clock");
      if (cycle > 100000 && !done_all) begin
         fails++; tests++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic wcyc(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic model_commit(bit lvl, int n, logic [15:0] w);
      if (!lvl && n == 16) begin
         case (w[15:14])
            2'b11: m_tx = w[13:0];
            2'b01: m_rx = w[13:0];
            2'b10: begin m_reg = w[13:12]; m_ref = w[11:0]; end
            default: m_ctrl = {w[12:5], 3'b000, w[1:0]};
         endcase
      end else if (lvl && ((n == 12 && w[11]) || (n == 16 && w[15]))) begin
         m_code = w[9:6];
         m_cap  = w[5:0];
      end
   endtask

   task automatic send(bit lvl, int n, logic [15:0] w);
      if (ser_en != lvl) begin
         quiet_until = cycle + 8;
         ser_en = lvl;
         wcyc(5);
      end
      for (int i = n - 1; i >= 0; i--) begin
         ser_data = w[i];
         wcyc(3);
         ser_clk = 1'b1;
         wcyc(4);
         ser_clk = 1'b0;
         wcyc(2);
      end
      wcyc(4);
      quiet_until = cycle + 8;
      ser_en = ~lvl;
      model_commit(lvl, n, w);
      wcyc(10);
   endtask

   initial begin
      wcyc(3);
      cmp_all("R1 in reset");
      rst_n = 1'b1;
      wcyc(6);
      chk("R1 tx default", tx_div, 9966);
      chk("R1 rx default", rx_div, 7215);
      chk("R1 ref default", ref_div, 2048);
      chk("R1 level default", batt_level, 1);

      send(1'b0, 16, {2'b11, 14'd5000});
      chk("R3 tx write", tx_div, 5000);
      send(1'b0, 16, {2'b01, 14'h2001});
      chk("R2 msb-first rx", rx_div, 14'h2001);
      send(1'b0, 16, {2'b10, 2'b10, 12'h7FF});
      chk("R4 ref div", ref_div, 12'h7FF);
      chk("R4 ref region", ref_region, 2);
      send(1'b0, 16, 16'b00_1_1010_1010_111_01);
      chk("R5 ctrl pattern A", ctrl_act(), m_ctrl);
      send(1'b0, 16, 16'b00_0_0101_0101_000_10);
      chk("R5 ctrl pattern B", ctrl_act(), m_ctrl);
      chk("R5 tx_save clear", tx_save, 0);

      send(1'b1, 16, {1'b1, 5'b11111, 4'b0100, 6'b101101});
      chk("R6 long cap", cap_sel, 6'b101101);
      chk("R8 level 0100", batt_level, 5'b01000);
      send(1'b1, 12, {4'h0, 1'b1, 1'b0, 4'b1000, 6'b011100});
      chk("R6 short cap", cap_sel, 6'b011100);
      chk("R8 level 1000", batt_level, 5'b10000);

      send(1'b1, 16, {1'b0, 5'b0, 4'b0001, 6'b111111});
      chk("R7 lead-zero ignored", cap_sel, 6'b011100);
      send(1'b0, 15, {1'b0, 2'b11, 13'd77});
      chk("R7 short low ignored", tx_div, 5000);
      send(1'b0, 17, {2'b11, 14'd33});
      chk("R7 long low ignored", tx_div, 5000);
      send(1'b1, 13, {3'b0, 1'b1, 2'b0, 4'b0001, 6'h3F});
      chk("R7 odd high ignored", batt_code, 4'b1000);

      send(1'b1, 12, {4'h0, 1'b1, 1'b1, 4'b0001, 6'h01});
      chk("R8 level 0001", batt_level, 5'b00010);
      send(1'b1, 12, {4'h0, 1'b1, 1'b0, 4'b0010, 6'h02});
      chk("R8 level 0010", batt_level, 5'b00100);
      send(1'b1, 12, {4'h0, 1'b1, 1'b0, 4'b0011, 6'h03});
      chk("R8 level other", batt_level, 5'b00001);
      send(1'b1, 16, {1'b1, 5'b0, 4'b0000, 6'h00});
      chk("R8 level 0000", batt_level, 5'b00001);

      send(1'b0, 16, {2'b11, 14'h3FFF});
      chk("R3 tx max", tx_div, 14'h3FFF);
      send(1'b0, 16, {2'b01, 14'd16});
      chk("R3 rx small", rx_div, 16);
      chk("R3 tx unchanged by rx", tx_div, 14'h3FFF);

      wcyc(20);
      done_all = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule